// File: doc/BRIEF.md
# Givens Rotation Row for QR-RLS Adaptation

This block is one row of a triangular systolic array used for recursive least squares adaptation by QR decomposition. It holds a boundary cell and a chain of internal cells. The boundary cell keeps a non-negative diagonal term R. For each new sample it folds the sample into R with an exponential forgetting factor and produces a Givens rotation pair (c, s). That pair then moves one cell per clock down the row. Each internal cell rotates its own input sample against its stored R, updates R, and emits the rotated residual that a lower row would consume.

All values are signed fixed point with `FRAC` fraction bits. The default is Q2.14 in 16 bits, where the code 16384 means 1.0. The square root of the forgetting factor, λ^½, is a constant parameter below 1.0. Its default of 16302 is about 0.995, which corresponds to λ ≈ 0.99. The boundary cell uses a sequential bit-serial square root and one shared sequential divider that produces c and then s. One sample is in flight at a time. It is accepted with a valid/ready handshake, and the whole row's results are presented together until they are taken. Weight back-substitution is not part of this block.

Top module: `qr_row`

## Requirements
- R1: After reset, c_o = 16384 (1.0), s_o = 0, r_diag_o = 0, every r_cell_o and x_rot_o entry is 0, out_valid_o = 0 and in_ready_o = 1.
- R2: For a sample with boundary input x (lane 0 of x_i), the boundary cell forms a = floor(L·R / 2^FRAC), where L is the λ^½ parameter. It then forms temp = floor(sqrt(a² + x²)), clamped to 2^(W-1)−1. The new R is temp, shown on r_diag_o, and it is never negative.
- R3: When temp ≠ 0, c = floor(a·2^FRAC / temp). s has the sign of x and the magnitude floor(|x|·2^FRAC / temp). c always lies in 0..16384.
- R4: When temp = 0, c = 16384, s = 0 and R = 0, and no division takes place.
- R5: Internal cell k, which takes lane k+1 of x_i, forms rl = floor(L·R_k / 2^FRAC). It then updates R_k to sat(floor((s·x + c·rl) / 2^FRAC)), where sat clamps to the signed W-bit range. R_k is shown on r_cell_o[k] and changes only when that cell is given a rotation pair.
- R6: Internal cell k outputs x_rot_o[k] = sat(floor((c·x − s·rl) / 2^FRAC)), using the R_k held before that sample's update.
- R7: The rotation pair moves unchanged from the boundary cell to cell 0, and from each cell to the next, one clock per cell. A cell updates only in the cycle its pair arrives, so every cell in the row uses the c and s of the same sample.
- R8: A sample is accepted on a clock edge where in_valid_i and in_ready_o are both high. in_ready_o stays low from acceptance until the results are taken. Any in_valid_i or x_i activity while in_ready_o is low has no effect on any result.
- R9: out_valid_o rises once the last cell has updated. It stays high with all outputs stable until a clock edge with out_ready_i high, after which out_valid_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample offered |
| in_ready_o | output | 1 | Row idle, sample can be accepted |
| x_i | input | (NUM_INT+1)·W | Sample lanes; lane 0 feeds the boundary cell, lane k+1 feeds internal cell k |
| out_valid_o | output | 1 | Row results available |
| out_ready_i | input | 1 | Results taken |
| c_o | output | W | Rotation cosine from the boundary cell |
| s_o | output | W | Rotation sine from the boundary cell |
| r_diag_o | output | W | Boundary cell diagonal R |
| r_cell_o | output | NUM_INT·W | Stored R of each internal cell |
| x_rot_o | output | NUM_INT·W | Rotated residual of each internal cell |

## Verification
The zero-temp branch is the hardest case to reach once R has become nonzero. It needs the decayed diagonal to floor all the way to zero while a zero sample arrives. The stimulus therefore seeds a tiny R and follows it with zero samples until the decay leaves a = 0. Clamping is reached by a burst of full-scale samples, including the most negative code. Random samples are applied between these directed cases, with held-off output acceptance and stray input strobes while the row is busy.

// File: rtl/qr_pkg.sv
package qr_pkg;
  typedef enum logic [1:0] {
    B_IDLE,
    B_SQRT,
    B_DIVC,
    B_DIVS
  } bstate_e;
endpackage

// File: rtl/qr_isqrt.sv
module qr_isqrt #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [2*W-1:0] rad_i,
  output logic           done_o,
  output logic [W-1:0]   root_o
);
  logic [2*W-1:0] rad_q;
  logic [W-1:0]   root_q, mask_q, trial;
  logic [2*W-1:0] trial_sq;
  logic           busy_q, done_q;

  assign trial    = root_q | mask_q;
  assign trial_sq = trial * trial;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rad_q  <= '0;
      root_q <= '0;
      mask_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      rad_q  <= rad_i;
      root_q <= '0;
      mask_q <= {1'b1, {(W-1){1'b0}}};
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (trial_sq <= rad_q) root_q <= trial;
      mask_q <= mask_q >> 1;
      if (mask_q[0]) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign root_o = root_q;
endmodule

// File: rtl/qr_divu.sv
module qr_divu #(
  parameter int W  = 16,
  parameter int DW = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] num_i,
  input  logic [W-1:0]  den_i,
  output logic          done_o,
  output logic [W-1:0]  quo_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] quo_q;
  logic [W:0]    rem_q, rem_sh;
  logic [W-1:0]  den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  assign rem_sh = {rem_q[W-1:0], quo_q[DW-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      quo_q  <= num_i;
      rem_q  <= '0;
      den_q  <= den_i;
      cnt_q  <= CW'(DW);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (rem_sh >= {1'b0, den_q}) begin
        rem_q <= rem_sh - {1'b0, den_q};
        quo_q <= {quo_q[DW-2:0], 1'b1};
      end else begin
        rem_q <= rem_sh;
        quo_q <= {quo_q[DW-2:0], 1'b0};
      end
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q[W-1:0];
endmodule

// File: rtl/qr_boundary_cell.sv
module qr_boundary_cell
  import qr_pkg::*;
#(
  parameter int W           = 16,
  parameter int FRAC        = 14,
  parameter int LAMBDA_SQRT = 16302
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic signed [W-1:0] x_i,
  output logic                valid_o,
  output logic signed [W-1:0] c_o,
  output logic signed [W-1:0] s_o,
  output logic [W-1:0]        r_o
);
  localparam int          DW   = W + FRAC;
  localparam logic [W-1:0] LSQ = W'(LAMBDA_SQRT);
  localparam logic [W-1:0] ONE = W'(1) << FRAC;
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};

  bstate_e        state_q;
  logic [W-1:0]   r_q, a_q, xabs_q, t_q, c_q, s_q;
  logic           xneg_q, valid_q;
  logic [2*W-1:0] a_prod, rad;
  logic [W-1:0]   a_w, x_abs, root, t_sat, quo;
  logic           sq_start, sq_done, dv_start, dv_done;
  logic [DW-1:0]  dv_num;
  logic [W-1:0]   dv_den;
  logic           unused_lo;

  assign a_prod    = LSQ * r_q;
  assign a_w       = a_prod[FRAC +: W];
  assign unused_lo = ^{a_prod[FRAC-1:0], a_prod[2*W-1:FRAC+W]};
  assign x_abs     = x_i[W-1] ? (~x_i + 1'b1) : x_i;
  assign rad       = a_w * a_w + x_abs * x_abs;
  assign sq_start  = start_i && (state_q == B_IDLE);
  assign t_sat     = (root > MAXP) ? MAXP : root;

  qr_isqrt #(.W(W)) i_sqrt (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(sq_start), .rad_i(rad),
    .done_o(sq_done), .root_o(root)
  );

  always_comb begin
    dv_start = 1'b0;
    dv_num   = {xabs_q, {FRAC{1'b0}}};
    dv_den   = t_q;
    if (state_q == B_SQRT && sq_done && t_sat != '0) begin
      dv_start = 1'b1;
      dv_num   = {a_q, {FRAC{1'b0}}};
      dv_den   = t_sat;
    end else if (state_q == B_DIVC && dv_done) begin
      dv_start = 1'b1;
    end
  end

  // shared divider: c first, then |s|
  qr_divu #(.W(W), .DW(DW)) i_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(dv_start), .num_i(dv_num),
    .den_i(dv_den), .done_o(dv_done), .quo_o(quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= B_IDLE;
      r_q     <= '0;
      a_q     <= '0;
      xabs_q  <= '0;
      xneg_q  <= 1'b0;
      t_q     <= '0;
      c_q     <= ONE;
      s_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        B_IDLE: if (start_i) begin
          a_q     <= a_w;
          xabs_q  <= x_abs;
          xneg_q  <= x_i[W-1];
          state_q <= B_SQRT;
        end
        B_SQRT: if (sq_done) begin
          if (t_sat == '0) begin
            c_q     <= ONE;
            s_q     <= '0;
            r_q     <= '0;
            valid_q <= 1'b1;
            state_q <= B_IDLE;
          end else begin
            t_q     <= t_sat;
            state_q <= B_DIVC;
          end
        end
        B_DIVC: if (dv_done) begin
          c_q     <= quo;
          state_q <= B_DIVS;
        end
        B_DIVS: if (dv_done) begin
          s_q     <= xneg_q ? (~quo + 1'b1) : quo;
          r_q     <= t_q;
          valid_q <= 1'b1;
          state_q <= B_IDLE;
        end
        default: state_q <= B_IDLE;
      endcase
    end
  end

  assign valid_o = valid_q;
  assign c_o     = c_q;
  assign s_o     = s_q;
  assign r_o     = r_q;

  a_r2_r_nonneg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_q[W-1]);
  a_r3_c_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (c_q <= ONE));
  a_r4_zero_temp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && r_q == '0) |-> (c_q == ONE && s_q == '0));
  a_r8_single_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q == B_IDLE) |=> (state_q == B_SQRT));
endmodule

// File: rtl/qr_internal_cell.sv
module qr_internal_cell #(
  parameter int W           = 16,
  parameter int FRAC        = 14,
  parameter int LAMBDA_SQRT = 16302
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic signed [W-1:0] c_i,
  input  logic signed [W-1:0] s_i,
  input  logic signed [W-1:0] x_i,
  output logic                valid_o,
  output logic signed [W-1:0] c_o,
  output logic signed [W-1:0] s_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] r_o
);
  localparam logic signed [W-1:0] LSQ = W'(LAMBDA_SQRT);

  function automatic logic signed [W-1:0] sat(input logic signed [2*W:0] v);
    if (v > $signed({{(W+2){1'b0}}, {(W-1){1'b1}}}))
      return {1'b0, {(W-1){1'b1}}};
    if (v < $signed({{(W+2){1'b1}}, {(W-1){1'b0}}}))
      return {1'b1, {(W-1){1'b0}}};
    return v[W-1:0];
  endfunction

  logic signed [W-1:0]   r_q, c_q, s_q, x_q, rl;
  logic                  valid_q;
  logic signed [2*W-1:0] rl_p, rl_sh, p_sx, p_cr, p_cx, p_sr;
  logic signed [2*W:0]   acc_r, acc_x, sh_r, sh_x;
  logic                  unused_hi;

  assign rl_p      = LSQ * r_q;
  assign rl_sh     = rl_p >>> FRAC;
  assign rl        = $signed(rl_sh[W-1:0]);
  assign unused_hi = ^rl_sh[2*W-1:W];
  assign p_sx      = s_i * x_i;
  assign p_cr      = c_i * rl;
  assign p_cx      = c_i * x_i;
  assign p_sr      = s_i * rl;
  assign acc_r     = p_sx + p_cr;
  assign acc_x     = p_cx - p_sr;
  assign sh_r      = acc_r >>> FRAC;
  assign sh_x      = acc_x >>> FRAC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q     <= '0;
      c_q     <= '0;
      s_q     <= '0;
      x_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        r_q <= sat(sh_r);
        x_q <= sat(sh_x);
        c_q <= c_i;
        s_q <= s_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign c_o     = c_q;
  assign s_o     = s_q;
  assign x_o     = x_q;
  assign r_o     = r_q;

  a_r5_r_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(r_q));
  a_r7_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (valid_o && c_o == $past(c_i) && s_o == $past(s_i)));
endmodule

// File: rtl/qr_row.sv
module qr_row #(
  parameter int W           = 16,
  parameter int FRAC        = 14,
  parameter int LAMBDA_SQRT = 16302,
  parameter int NUM_INT     = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  output logic                        in_ready_o,
  input  logic [NUM_INT:0][W-1:0]     x_i,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic [W-1:0]                c_o,
  output logic [W-1:0]                s_o,
  output logic [W-1:0]                r_diag_o,
  output logic [NUM_INT-1:0][W-1:0]   r_cell_o,
  output logic [NUM_INT-1:0][W-1:0]   x_rot_o
);
  logic                      busy_q, out_valid_q, accept;
  logic [NUM_INT:0][W-1:0]   x_q;
  logic                      bc_valid;
  logic signed [W-1:0]       bc_c, bc_s;
  logic [W-1:0]              bc_r;
  logic [NUM_INT-1:0]        cv;
  logic [NUM_INT-1:0][W-1:0] cc, cs;
  logic                      unused_tail;

  assign accept = in_valid_i && !busy_q;

  qr_boundary_cell #(.W(W), .FRAC(FRAC), .LAMBDA_SQRT(LAMBDA_SQRT)) i_bc (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept), .x_i(x_i[0]),
    .valid_o(bc_valid), .c_o(bc_c), .s_o(bc_s), .r_o(bc_r)
  );

  for (genvar k = 0; k < NUM_INT; k++) begin : g_cell
    logic                v_in;
    logic signed [W-1:0] c_in, s_in;
    if (k == 0) begin : g_head
      assign v_in = bc_valid;
      assign c_in = bc_c;
      assign s_in = bc_s;
    end else begin : g_link
      assign v_in = cv[k-1];
      assign c_in = cc[k-1];
      assign s_in = cs[k-1];
    end
    qr_internal_cell #(.W(W), .FRAC(FRAC), .LAMBDA_SQRT(LAMBDA_SQRT)) i_ic (
      .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(v_in), .c_i(c_in), .s_i(s_in),
      .x_i(x_q[k+1]), .valid_o(cv[k]), .c_o(cc[k]), .s_o(cs[k]),
      .x_o(x_rot_o[k]), .r_o(r_cell_o[k])
    );
  end

  assign unused_tail = ^{cc[NUM_INT-1], cs[NUM_INT-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      out_valid_q <= 1'b0;
      x_q         <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        x_q    <= x_i;
      end
      if (cv[NUM_INT-1]) begin
        out_valid_q <= 1'b1;
      end else if (out_valid_q && out_ready_i) begin
        out_valid_q <= 1'b0;
        busy_q      <= 1'b0;
      end
    end
  end

  assign in_ready_o  = !busy_q;
  assign out_valid_o = out_valid_q;
  assign c_o         = bc_c;
  assign s_o         = bc_s;
  assign r_diag_o    = bc_r;

  a_r8_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);
  a_r8_lanes_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_ready_o && !$past(in_ready_o)) |-> $stable(x_q));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(c_o) && $stable(s_o)
                                      && $stable(r_cell_o) && $stable(x_rot_o)));
  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |=> (!out_valid_o && in_ready_o));
endmodule

// File: tb/test_qr_row.sv
module test_qr_row;
  localparam int W = 16, FRAC = 14, LSQ = 16302, N = 2;
  localparam longint ONE = 64'sd1 <<< FRAC;
  localparam longint MAXP = (64'sd1 <<< (W-1)) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [N:0][W-1:0] x_in = '0;
  logic in_ready, out_valid;
  logic [W-1:0] c_out, s_out, r_diag;
  logic [N-1:0][W-1:0] r_cell, x_rot;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  longint m_rb = 0;
  longint m_rc [N];
  longint xs [N+1];

  always #10 clk = ~clk;

  qr_row #(.W(W), .FRAC(FRAC), .LAMBDA_SQRT(LSQ), .NUM_INT(N)) i_qr_row (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .x_i(x_in), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .c_o(c_out), .s_o(s_out), .r_diag_o(r_diag), .r_cell_o(r_cell), .x_rot_o(x_rot)
  );

  function automatic longint sv(input logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint sat(input longint v);
    if (v > MAXP) return MAXP;
    if (v < -MAXP - 1) return -MAXP - 1;
    return v;
  endfunction

  function automatic longint fsqrt(input longint q);
    longint r = longint'($sqrt(real'(q)));
    while (r * r > q) r--;
    while ((r + 1) * (r + 1) <= q) r++;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic run_sample(input bit stray, input int hold);
    longint a, q, t, ec, es, rl, ex, er;
    int w;
    @(negedge clk);
    check(in_ready == 1'b1, "R8 ready before offer", longint'(in_ready), 1);
    in_valid = 1'b1;
    for (int k = 0; k <= N; k++) x_in[k] = W'(xs[k]);
    @(negedge clk);
    check(in_ready == 1'b0, "R8 busy after accept", longint'(in_ready), 0);
    if (stray) begin
      for (int k = 0; k <= N; k++) x_in[k] = W'($urandom);
      repeat (3) @(negedge clk);
    end
    in_valid = 1'b0;
    w = 0;
    while (!out_valid && w < 1000) begin
      @(negedge clk);
      w++;
    end
    check(out_valid == 1'b1, "R9 result appears", longint'(out_valid), 1);
    // reference model, R2/R3/R4
    a = (LSQ * m_rb) >>> FRAC;
    q = a * a + xs[0] * xs[0];
    t = fsqrt(q);
    if (t > MAXP) t = MAXP;
    if (t == 0) begin
      ec = ONE; es = 0; m_rb = 0;
    end else begin
      ec = (a <<< FRAC) / t;
      es = ((xs[0] < 0 ? -xs[0] : xs[0]) <<< FRAC) / t;
      if (xs[0] < 0) es = -es;
      m_rb = t;
    end
    if (t == 0) begin
      check(sv(c_out) == ONE, "R4 c zero temp", sv(c_out), ONE);
      check(sv(s_out) == 0, "R4 s zero temp", sv(s_out), 0);
    end else begin
      check(sv(c_out) == ec, "R3 c", sv(c_out), ec);
      check(sv(s_out) == es, "R3 s", sv(s_out), es);
    end
    check(longint'(r_diag) == m_rb, "R2 diagonal", longint'(r_diag), m_rb);
    // R5/R6, with R7 pair reuse along the row
    for (int k = 0; k < N; k++) begin
      rl = (LSQ * m_rc[k]) >>> FRAC;
      er = sat((es * xs[k+1] + ec * rl) >>> FRAC);
      ex = sat((ec * xs[k+1] - es * rl) >>> FRAC);
      m_rc[k] = er;
      check(sv(r_cell[k]) == er, "R5 R7 cell R", sv(r_cell[k]), er);
      check(sv(x_rot[k]) == ex, "R6 R7 cell x_out", sv(x_rot[k]), ex);
    end
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(out_valid == 1'b1 && sv(c_out) == ec && sv(r_cell[N-1]) == m_rc[N-1],
            "R9 hold", longint'(out_valid), 1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9 release",
          longint'({out_valid, in_ready}), 1);
  endtask

  task automatic set_x(input longint a0, input longint a1, input longint a2);
    xs[0] = a0; xs[1] = a1; xs[2] = a2;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int k = 0; k < N; k++) m_rc[k] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sv(c_out) == ONE, "R1 c", sv(c_out), ONE);
    check(sv(s_out) == 0, "R1 s", sv(s_out), 0);
    check(r_diag == '0 && r_cell == '0 && x_rot == '0, "R1 R state", longint'(r_diag), 0);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 handshake",
          longint'({out_valid, in_ready}), 1);
    rst_n = 1'b1;
    // R4 from reset, then drained diagonal back to zero
    set_x(0, 100, -100);  run_sample(1'b0, 0);
    set_x(3, 50, 7);      run_sample(1'b0, 1);
    for (int i = 0; i < 4; i++) begin
      set_x(0, 0, 0);
      run_sample(1'b1, 0);
    end
    // sign of s
    set_x(-4000, 1200, -3000); run_sample(1'b0, 2);
    set_x(6000, -8000, 8000);  run_sample(1'b1, 0);
    // random phase
    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k <= N; k++) xs[k] = longint'($urandom_range(0, 16383)) - 8192;
      run_sample(($urandom % 2) == 1, int'($urandom % 3));
    end
    // R2 clamp with full scale
    for (int i = 0; i < 6; i++) begin
      set_x((i % 2) ? 32767 : -32768, -32768, 32767);
      run_sample(1'b0, 0);
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule